// File: doc/BRIEF.md
# Lockable Dual-Path Byte NVRAM

This block is a byte-addressed storage array with two ways in. The indirect port works in two steps. An address-set operation loads a latched pointer, and later byte reads and writes act at that pointer. On this port two 16-byte windows can be write- and read-protected by two lock bits, and each lock bit is flipped by a toggle command. The CPU port is mapped at a base address. It moves a byte, a halfword or a word per request, in big-endian order, and it also accepts unaligned requests.

After reset a small sequencer writes an identification record near the top of storage. The record holds a fixed format byte, a fixed type byte, a 6-byte hardware address taken from an input, and seven zero bytes. The byte after the record gets the XOR of those 15 bytes. While the sequencer runs, `ready` is low and no request is served. When both ports want the storage in the same cycle, the CPU port wins and the indirect operation waits in a one-entry slot.

Top module: `lockable_nvram`

## Requirements
- R1: After reset both lock bits are clear. `ready` is low and rises exactly 16 clock edges after reset is released. Once high it stays high.
- R2: The ID record starts at byte DEPTH-40 (0x7D8 at the default DEPTH of 2048). It holds 0x01, then 0x80, then `hw_id[47:40]` down to `hw_id[7:0]` in the next six bytes, then zeros up to offset 14.
- R3: The byte at DEPTH-25 (0x7E7 by default) equals the XOR of the 15 record bytes.
- R4: A cycle with `ix_addr_set` high latches `ix_addr`. Later `ix_rd`/`ix_wr` operations use the latched address, not the live `ix_addr` input.
- R5: An indirect operation issued while `ready` is high and `cpu_req` is low gets `ix_ack` one edge later. On a read, `ix_rdata` is valid in that same cycle.
- R6: Indirect bytes 0x20–0x2F are guarded by lock bit 0 and bytes 0x30–0x3F by lock bit 1. A guarded write is dropped and a guarded read returns 0xFF. Addresses outside both windows are not affected by either bit.
- R7: A cycle with `lock_flip` high inverts lock bit `lock_sel`. Flipping it again restores access, and the stored data is unchanged.
- R8: An indirect address at or above DEPTH reads 0xFF. A write to it changes no stored byte, including the byte it would alias to. Both operations are still acknowledged.
- R9: `cpu_size` codes are 0 = byte, 1 = halfword, 2 or 3 = word. A request is taken in any cycle with `cpu_req` and `ready` both high, and `cpu_ack` follows one edge later with `cpu_rdata`.
- R10: Multi-byte transfers are big-endian. The most significant byte is at the lowest address, any byte alignment is allowed, and a read is right-justified in `cpu_rdata` with the unused upper bits zero.
- R11: The CPU offset is `cpu_addr - CPU_BASE`, taken as unsigned. A request is in range only if offset + size ≤ DEPTH. Out of range, a read returns 0 and a write changes nothing.
- R12: An indirect operation issued in the same cycle as an accepted CPU request is held. Its `ix_acks` comes two edges after issue instead of one.
- R13: While `ready` is low, `cpu_req` gets no acknowledgement, and indirect operations wait until the record is built.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_id | input | 48 | Hardware address copied into the ID record |
| ready | output | 1 | ID record built, ports open |
| cpu_req | input | 1 | CPU request strobe |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_size | input | 2 | Transfer size code |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | Write data, right-justified |
| cpu_ack | output | 1 | CPU request completed |
| cpu_rdata | output | 32 | Read data, right-justified, valid with `cpu_ack` |
| ix_addr_set | input | 1 | Latch the indirect pointer |
| ix_addr | input | IXW | New indirect pointer value |
| ix_rd | input | 1 | Indirect read at the latched pointer |
| ix_wr | input | 1 | Indirect write at the latched pointer |
| ix_wdata | input | 8 | Indirect write byte |
| ix_ack | output | 1 | Indirect operation completed |
| ix_rdata | output | 8 | Indirect read byte, valid with `ix_ack` |
| lock_flip | input | 1 | Invert the selected lock bit |
| lock_sel | input | 1 | Lock bit index |

## Verification
CPU results, both ack and data, are due one clock edge after the request is taken. Indirect results are due one edge after issue, or two when a CPU request takes the same cycle. `ready` is due 16 edges after reset is released. The bench drives each stimulus on a falling edge and reads the outputs at the next falling edge. In the collision case it checks both the missing acknowledgement at one edge and its arrival at the next. Effects that cannot be seen directly, such as dropped writes, blocked lanes and aliasing addresses, are checked by reading the affected bytes back through the other port or after unlocking.

// File: rtl/nvram_pkg.sv
package nvram_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_WORD_ALT = 2'd3} acc_size_e;

  localparam logic [7:0] ID_FORMAT = 8'h01;
  localparam logic [7:0] ID_TYPE   = 8'h80;
  localparam int         ID_BYTES  = 15;
  localparam int         ID_FROM_TOP = 40;

  function automatic logic [2:0] size_bytes(acc_size_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/nvram_bank.sv
module nvram_bank #(
  parameter int ROWS = 512,
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [7:0]    wd,
  output logic [7:0]    rd
);
  logic [7:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wd;
    rd <= mem[row];
  end
endmodule

// File: rtl/nvram_idinit.sv
module nvram_idinit #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int ID_OFS = DEPTH - nvram_pkg::ID_FROM_TOP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [47:0]   hw_id,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          ready
);
  logic [3:0] cnt;
  logic [7:0] acc;
  logic [7:0] cur;

  always_comb begin
    case (cnt)
      4'd0: cur = nvram_pkg::ID_FORMAT;
      4'd1: cur = nvram_pkg::ID_TYPE;
      4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: cur = hw_id[{3'(4'd7 - cnt), 3'b000} +: 8];
      default: cur = 8'h00;
    endcase
  end

  assign wr_en   = !ready;
  assign wr_addr = AW'(ID_OFS) + AW'(cnt);
  assign wr_data = (cnt == 4'(nvram_pkg::ID_BYTES)) ? acc : cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      acc   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt == 4'(nvram_pkg::ID_BYTES)) begin
        ready <= 1'b1;
      end else begin
        acc <= acc ^ cur;
        cnt <= cnt + 4'd1;
      end
    end
  end
endmodule

// File: rtl/nvram_guard.sv
module nvram_guard #(
  parameter int DEPTH = 2048,
  parameter int IXW   = 16
) (
  input  logic [IXW-1:0] addr,
  input  logic [1:0]     lock,
  output logic           allow
);
  logic in_store, win0, win1;

  assign in_store = 32'(addr) < DEPTH;
  assign win0     = addr[IXW-1:4] == (IXW-4)'(2);
  assign win1     = addr[IXW-1:4] == (IXW-4)'(3);
  assign allow    = in_store && !(win0 && lock[0]) && !(win1 && lock[1]);
endmodule

// File: rtl/lockable_nvram.sv
module lockable_nvram #(
  parameter int          DEPTH    = 2048,
  parameter logic [31:0] CPU_BASE = 32'h0000_8000,
  parameter int          IXW      = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [47:0]    hw_id,
  output logic           ready,
  input  logic           cpu_req,
  input  logic           cpu_we,
  input  logic [1:0]     cpu_size,
  input  logic [31:0]    cpu_addr,
  input  logic [31:0]    cpu_wdata,
  output logic           cpu_ack,
  output logic [31:0]    cpu_rdata,
  input  logic           ix_addr_set,
  input  logic [IXW-1:0] ix_addr,
  input  logic           ix_rd,
  input  logic           ix_wr,
  input  logic [7:0]     ix_wdata,
  output logic           ix_ack,
  output logic [7:0]     ix_rdata,
  input  logic           lock_flip,
  input  logic           lock_sel
);
  localparam int AW   = $clog2(DEPTH);
  localparam int ROWS = DEPTH / 4;
  localparam int RW   = $clog2(ROWS);

  logic          init_we;
  logic [AW-1:0] init_addr;
  logic [7:0]    init_data;

  nvram_idinit #(.DEPTH(DEPTH)) u_init (
    .clk(clk), .rst(rst), .hw_id(hw_id),
    .wr_en(init_we), .wr_addr(init_addr), .wr_data(init_data), .ready(ready)
  );

  logic [IXW-1:0] ix_addr_q;
  logic [1:0]     lock_q;
  logic           ix_ok;

  nvram_guard #(.DEPTH(DEPTH), .IXW(IXW)) u_guard (
    .addr(ix_addr_q), .lock(lock_q), .allow(ix_ok)
  );

  logic        cpu_go, cpu_ok;
  logic [31:0] off;
  logic [2:0]  cpu_n;

  assign cpu_go = ready && cpu_req;
  assign off    = cpu_addr - CPU_BASE;
  assign cpu_n  = nvram_pkg::size_bytes(nvram_pkg::acc_size_e'(cpu_size));
  assign cpu_ok = off <= (32'(DEPTH) - 32'(cpu_n));

  logic       pend_v, pend_wr;
  logic [7:0] pend_wd;
  logic       ix_act, ix_exec, ix_op_wr;
  logic [7:0] ix_op_wd;

  assign ix_act   = ix_rd || ix_wr || pend_v;
  assign ix_exec  = ix_act && ready && !cpu_go;
  assign ix_op_wr = pend_v ? pend_wr : ix_wr;
  assign ix_op_wd = pend_v ? pend_wd : ix_wdata;

  logic [RW-1:0] b_row [4];
  logic [3:0]    b_we;
  logic [7:0]    b_wd  [4];
  logic [7:0]    b_rd  [4];

  always_comb begin
    logic [1:0] lane;
    logic [2:0] pos;
    for (int b = 0; b < 4; b++) begin
      b_row[b] = '0;
      b_we[b]  = 1'b0;
      b_wd[b]  = '0;
      lane     = 2'(b) - off[1:0];
      pos      = cpu_n - 3'd1 - {1'b0, lane};
      if (!ready) begin
        b_row[b] = init_addr[AW-1:2];
        b_wd[b]  = init_data;
        b_we[b]  = init_we && (init_addr[1:0] == 2'(b));
      end else if (cpu_go) begin
        b_row[b] = off[AW-1:2] + ((2'(b) < off[1:0]) ? RW'(1) : RW'(0));
        b_we[b]  = cpu_we && cpu_ok && ({1'b0, lane} < cpu_n);
        b_wd[b]  = cpu_wdata[{pos[1:0], 3'b000} +: 8];
      end else if (ix_exec) begin
        b_row[b] = ix_addr_q[AW-1:2];
        b_we[b]  = ix_op_wr && ix_ok && (ix_addr_q[1:0] == 2'(b));
        b_wd[b]  = ix_op_wd;
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    nvram_bank #(.ROWS(ROWS)) u_bank (
      .clk(clk), .we(b_we[g]), .row(b_row[g]), .wd(b_wd[g]), .rd(b_rd[g])
    );
  end

  logic [1:0] cpu_lane_q, ix_lane_q;
  logic [2:0] cpu_n_q;
  logic       cpu_hit_q, ix_blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ack   <= 1'b0;
      ix_ack    <= 1'b0;
      pend_v    <= 1'b0;
      lock_q    <= '0;
      ix_addr_q <= '0;
      cpu_hit_q <= 1'b0;
      ix_blk_q  <= 1'b0;
    end else begin
      cpu_ack   <= cpu_go;
      cpu_hit_q <= cpu_go && cpu_ok;
      ix_ack    <= ix_exec;
      if (ix_exec) ix_blk_q <= !ix_ok;
      if (ix_addr_set) ix_addr_q <= ix_addr;
      if (lock_flip) lock_q[lock_sel] <= ~lock_q[lock_sel];
      if (ix_exec) pend_v <= 1'b0;
      else if (ix_act) pend_v <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_go) begin
      cpu_lane_q <= off[1:0];
      cpu_n_q    <= cpu_n;
    end
    if (ix_exec) ix_lane_q <= ix_addr_q[1:0];
    if (ix_act && !ix_exec && !pend_v) begin
      pend_wr <= ix_wr;
      pend_wd <= ix_wdata;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_hit_q) begin
      for (int k = 0; k < 4; k++) begin
        if (k < int'(cpu_n_q))
          cpu_rdata = cpu_rdata | ({24'b0, b_rd[cpu_lane_q + 2'(k)]} << (8 * (int'(cpu_n_q) - 1 - k)));
      end
    end
  end

  assign ix_rdata = ix_blk_q ? 8'hFF : b_rd[ix_lane_q];
endmodule

// File: rtl/lockable_nvram_chk.sv
module lockable_nvram_chk #(
  parameter logic [31:0] CPU_BASE = 32'h0000_8000
) (
  input logic        clk,
  input logic        rst,
  input logic        ready,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic [31:0] cpu_addr,
  input logic        cpu_ack,
  input logic [31:0] cpu_rdata,
  input logic        ix_rd,
  input logic        ix_wr,
  input logic        ix_ack,
  input logic        pend_v,
  input logic        lock_flip,
  input logic [1:0]  lock_q
);
  assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (rst) ready |=> ready);

  assert_cpu_ack_R9: assert property (@(posedge clk) disable iff (rst) (cpu_req && ready) |=> cpu_ack);

  assert_cpu_stall_R13: assert property (@(posedge clk) disable iff (rst) !(cpu_req && ready) |=> !cpu_ack);

  assert_ix_quiet_R13: assert property (@(posedge clk) disable iff (rst) !ready |-> !ix_ack);

  assert_ix_ack_R5: assert property (@(posedge clk) disable iff (rst)
    ((ix_rd || ix_wr) && !pend_v && ready && !cpu_req) |=> ix_ack);

  assert_ix_hold_R12: assert property (@(posedge clk) disable iff (rst)
    ((ix_rd || ix_wr) && !pend_v && ready && cpu_req) |=> !ix_ack);

  assert_lock_flip_R7: assert property (@(posedge clk) disable iff (rst) lock_flip |=> (lock_q != $past(lock_q)));

  assert_lock_keep_R7: assert property (@(posedge clk) disable iff (rst) !lock_flip |=> $stable(lock_q));

  assert_below_base_R11: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && ready && !cpu_we && (cpu_addr < CPU_BASE)) |=> (cpu_rdata == 32'h0));
endmodule

bind lockable_nvram lockable_nvram_chk #(.CPU_BASE(CPU_BASE)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
  .ix_rd(ix_rd), .ix_wr(ix_wr), .ix_ack(ix_ack), .pend_v(pend_v),
  .lock_flip(lock_flip), .lock_q(lock_q)
);

// File: tb/lockable_nvram_tb.sv
module lockable_nvram_tb;
  localparam int          DEPTH = 2048;
  localparam logic [31:0] BASE  = 32'h0000_8000;
  localparam int          IDO   = DEPTH - 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [47:0] hw_id = 48'h02_1A_B3_C4_D5_E6;
  logic        ready;
  logic        cpu_req = 0, cpu_we = 0;
  logic [1:0]  cpu_size = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic        cpu_ack;
  logic [31:0] cpu_rdata;
  logic        ix_addr_set = 0, ix_rd = 0, ix_wr = 0;
  logic [15:0] ix_addr = 0;
  logic [7:0]  ix_wdata = 0;
  logic        ix_ack;
  logic [7:0]  ix_rdata;
  logic        lock_flip = 0, lock_sel = 0;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  lockable_nvram #(.DEPTH(DEPTH), .CPU_BASE(BASE), .IXW(16)) u_dut (
    .clk(clk), .rst(rst), .hw_id(hw_id), .ready(ready),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .ix_addr_set(ix_addr_set), .ix_addr(ix_addr), .ix_rd(ix_rd), .ix_wr(ix_wr),
    .ix_wdata(ix_wdata), .ix_ack(ix_ack), .ix_rdata(ix_rdata),
    .lock_flip(lock_flip), .lock_sel(lock_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ix_point(input logic [15:0] a);
    @(negedge clk); ix_addr_set = 1; ix_addr = a;
    @(negedge clk); ix_addr_set = 0; ix_addr = 16'hFFFF;
  endtask

  task automatic ix_write(input logic [15:0] a, input logic [7:0] d);
    ix_point(a);
    ix_wr = 1; ix_wdata = d;
    @(negedge clk); ix_wr = 0;
    chk("R5 write ack", 32'(ix_ack), 1);
  endtask

  task automatic ix_read(input logic [15:0] a, output logic [7:0] d);
    ix_point(a);
    ix_rd = 1;
    @(negedge clk); ix_rd = 0;
    chk("R5 read ack", 32'(ix_ack), 1);
    d = ix_rdata;
  endtask

  task automatic cpu_op(input logic we, input logic [1:0] sz, input logic [31:0] off,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_size = sz; cpu_addr = BASE + off; cpu_wdata = wd;
    @(negedge clk); cpu_req = 0; cpu_we = 0;
    chk("R9 cpu ack", 32'(cpu_ack), 1);
    rd = cpu_rdata;
  endtask

  task automatic flip(input logic s);
    @(negedge clk); lock_flip = 1; lock_sel = s;
    @(negedge clk); lock_flip = 0;
  endtask

  task automatic t_reset();
    int n = 0;
    chk("R1 ready low after reset", 32'(ready), 0);
    cpu_req = 1; cpu_addr = BASE;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (i == 3) begin
        chk("R13 no cpu ack before ready", 32'(cpu_ack), 0);
        cpu_req = 0;
      end
      if (ready && n == 0) n = i;
    end
    chk("R1 ready after 16 edges", n, 16);
    chk("R1 ready stays high", 32'(ready), 1);
  endtask

  task automatic t_id();
    logic [31:0] r;
    logic [7:0]  cks, b;
    cks = 8'h01 ^ 8'h80;
    for (int i = 0; i < 6; i++) cks = cks ^ hw_id[8*(5-i) +: 8];
    cpu_op(0, 2, IDO, 0, r);      chk("R2 id word 0", r, {8'h01, 8'h80, hw_id[47:32]});
    cpu_op(0, 2, IDO + 4, 0, r);  chk("R2 id word 1", r, hw_id[31:0]);
    cpu_op(0, 2, IDO + 8, 0, r);  chk("R2 id zero bytes", r, 0);
    cpu_op(0, 2, IDO + 12, 0, r); chk("R3 checksum word", r, {24'h0, cks});
    ix_read(16'(IDO + 15), b);    chk("R3 checksum by indirect port", 32'(b), 32'(cks));
  endtask

  task automatic t_ix_basic();
    logic [7:0] b;
    ix_write(16'h0100, 8'h5A);
    ix_write(16'h0101, 8'hA7);
    ix_read(16'h0100, b); chk("R4 readback 0x100", 32'(b), 32'h5A);
    ix_read(16'h0101, b); chk("R4 readback 0x101", 32'(b), 32'hA7);
  endtask

  task automatic t_lock();
    logic [7:0] b;
    ix_write(16'h0025, 8'h11);
    ix_write(16'h0035, 8'h22);
    ix_write(16'h0040, 8'h44);
    flip(0);
    ix_write(16'h0025, 8'h99);
    ix_read(16'h0025, b); chk("R6 lock0 read blocked", 32'(b), 32'hFF);
    ix_read(16'h0035, b); chk("R6 lock0 leaves 0x35", 32'(b), 32'h22);
    ix_read(16'h0040, b); chk("R6 lock0 leaves 0x40", 32'(b), 32'h44);
    flip(0);
    ix_read(16'h0025, b); chk("R7 unlock, write was dropped", 32'(b), 32'h11);
    flip(1);
    ix_write(16'h0035, 8'h77);
    ix_read(16'h0035, b); chk("R6 lock1 read blocked", 32'(b), 32'hFF);
    ix_read(16'h0025, b); chk("R6 lock1 leaves 0x25", 32'(b), 32'h11);
    flip(1);
    ix_read(16'h0035, b); chk("R7 lock1 restored", 32'(b), 32'h22);
  endtask

  task automatic t_ix_oor();
    logic [7:0] b;
    ix_write(16'h0000, 8'h33);
    ix_write(16'(DEPTH), 8'hCC);
    ix_read(16'(DEPTH), b); chk("R8 oor read 0xFF", 32'(b), 32'hFF);
    ix_read(16'h0000, b);   chk("R8 oor write no alias", 32'(b), 32'h33);
  endtask

  task automatic t_cpu();
    logic [31:0] r;
    logic [7:0]  b;
    cpu_op(1, 2, 32'h200, 32'h11223344, r);
    for (int i = 0; i < 4; i++) begin
      ix_read(16'(32'h200 + i), b);
      chk("R10 word byte order", 32'(b), 32'h11 * (i + 1));
    end
    cpu_op(0, 1, 32'h201, 0, r); chk("R10 halfword read", r, 32'h2233);
    cpu_op(0, 0, 32'h203, 0, r); chk("R9 byte read", r, 32'h44);
    cpu_op(1, 2, 32'h301, 32'hA1B2C3D4, r);
    ix_read(16'h0301, b); chk("R10 unaligned byte 0", 32'(b), 32'hA1);
    ix_read(16'h0304, b); chk("R10 unaligned byte 3", 32'(b), 32'hD4);
    cpu_op(0, 3, 32'h301, 0, r); chk("R9 size 3 is word", r, 32'hA1B2C3D4);
    cpu_op(1, 1, 32'h305, 32'hFFFF_5566, r);
    cpu_op(0, 2, 32'h303, 0, r); chk("R10 halfword write", r, 32'hC3D45566);
  endtask

  task automatic t_range();
    logic [31:0] r;
    logic [7:0]  b;
    ix_write(16'(DEPTH - 2), 8'h5C);
    ix_write(16'(DEPTH - 1), 8'h6D);
    cpu_op(1, 2, 32'(DEPTH - 2), 32'hDEADBEEF, r);
    ix_read(16'(DEPTH - 2), b); chk("R11 straddling write ignored", 32'(b), 32'h5C);
    cpu_op(0, 1, 32'(DEPTH - 2), 0, r); chk("R11 last halfword in range", r, 32'h5C6D);
    cpu_op(0, 2, 32'(DEPTH - 2), 0, r); chk("R11 straddling read zero", r, 0);
    cpu_op(0, 2, 32'hFFFF_FFFC, 0, r);  chk("R11 below base read zero", r, 0);
  endtask

  task automatic t_priority();
    ix_point(16'h0100);
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_size = 2; cpu_addr = BASE + 32'h200; ix_rd = 1;
    @(negedge clk); cpu_req = 0; ix_rd = 0;
    chk("R12 cpu served first", 32'(cpu_ack), 1);
    chk("R12 cpu data", cpu_rdata, 32'h11223344);
    chk("R12 indirect held", 32'(ix_ack), 0);
    @(negedge clk);
    chk("R12 indirect ack one edge late", 32'(ix_ack), 1);
    chk("R12 indirect data", 32'(ix_rdata), 32'h5A);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_id();
    t_ix_basic();
    t_lock();
    t_ix_oor();
    t_cpu();
    t_range();
    t_priority();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1-R13 run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule